// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

This block drives one DMA channel from a loaded configuration to completion. When it is started while idle it captures a source address, a destination address, a width code for each side, a burst-length code, an address mode for each side and a transfer size. The transfer size is counted in source-width units. The block then issues read and write beats on a request/acknowledge memory port. Each beat carries an address, a direction and a size code.

Work proceeds in groups. A group is up to 2^burst source units. The block reads every unit of the group first and then writes the same bytes back out in destination-width beats. After each acknowledged beat the address on that side steps by the beat width, in the direction set by that side's mode.

The residue count can be read at any time and falls by one as each unit's last write completes. The block ends a transfer in one of three ways, each with its own one-cycle pulse:
- terminal count, when the residue reaches zero;
- error, when a beat response is flagged as failed;
- abort, which takes effect at the next acknowledged beat after the abort request.

Top module: `dma_seq`

## Requirements
- R1: After reset, busy_o, mem_req_o, tc_o, err_o and abort_o are low and residue_o is zero.
- R2: A start pulse while idle loads the configuration. busy_o is high and residue_o equals size_i in the next cycle. A start pulse while busy has no effect on the running transfer.
- R3: Work proceeds in groups of G = min(2^b, residue) units, where b is burst_i (values above 10 act as 10). All G reads (mem_we_o=0) are issued first, then all writes for those G units (mem_we_o=1).
- R4: Width code w means a beat of 2^w bytes: 0 byte, 1 halfword, 2 word, 3 doubleword. A read has size code src_width_i. A write has size code d = min(dst_width_i, src_width_i), and each unit takes 2^(src_width_i−d) writes.
- R5: After each acknowledged beat, the address on that side changes by 2^size bytes. Mode 0 increments it, mode 1 decrements it, and modes 2 and 3 hold it. The source and destination use their own mode inputs.
- R6: residue_o falls by exactly one when the last write beat of a unit is acknowledged. Otherwise it does not change while busy.
- R7: When residue_o reaches zero, tc_o pulses for one cycle and busy_o and mem_req_o drop in that same cycle. A start with size_i of zero pulses tc_o in the next cycle and issues no beat.
- R8: A request that has not been acknowledged stays asserted with address, direction and size unchanged.
- R9: An acknowledged beat with mem_err_i high ends the transfer. err_o pulses for one cycle and residue_o keeps its value from before that beat.
- R10: abort_i while busy ends the transfer at the next acknowledged beat, which still completes. abort_o then pulses for one cycle, unless that beat finished the last unit, in which case tc_o pulses instead. abort_i while idle is ignored.
- R11: At most one of tc_o, err_o and abort_o is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load configuration and begin (idle only) |
| src_addr_i | input | AW | Initial source address |
| dst_addr_i | input | AW | Initial destination address |
| src_width_i | input | 2 | Source width code |
| dst_width_i | input | 2 | Destination width code |
| burst_i | input | 4 | Burst code, 2^code units per group |
| src_mode_i | input | 2 | Source address mode |
| dst_mode_i | input | 2 | Destination address mode |
| size_i | input | CW | Transfer size in source units |
| abort_i | input | 1 | Abort request |
| mem_ack_i | input | 1 | Beat acknowledge |
| mem_err_i | input | 1 | Beat failed, valid with acknowledge |
| mem_req_o | output | 1 | Beat request |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | AW | Beat address |
| mem_size_o | output | 2 | Beat size code |
| residue_o | output | CW | Remaining source units |
| busy_o | output | 1 | Transfer in progress |
| tc_o | output | 1 | Terminal-count pulse |
| err_o | output | 1 | Error pulse |
| abort_o | output | 1 | Abort pulse |

## Verification
A wrong group counter or sub-beat counter shows up at the port within one beat. It appears either as a read where a write belongs or as a wrong beat count before the direction flips. A wrong address register appears on mem_addr_o at the very next request, so the bench compares every acknowledged beat against a model built from the requirements. A residue or stop-condition fault appears in the final residue, in which pulse fires, and in how many beats were issued. The error and abort cases are placed both in the middle of a group and on the final beat.

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [1:0]    src_width_i,
  input  logic [1:0]    dst_width_i,
  input  logic [3:0]    burst_i,
  input  logic [1:0]    src_mode_i,
  input  logic [1:0]    dst_mode_i,
  input  logic [CW-1:0] size_i,
  input  logic          abort_i,
  input  logic          mem_ack_i,
  input  logic          mem_err_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [CW-1:0] residue_o,
  output logic          busy_o,
  output logic          tc_o,
  output logic          err_o,
  output logic          abort_o
);
  localparam int BW = 11;

  typedef enum logic [1:0] {IDLE, RD, WR} st_t;
  st_t st;

  logic [AW-1:0] src_a, dst_a;
  logic [1:0]    sw, dw, sm, dm;
  logic [3:0]    bc;
  logic [CW-1:0] res;
  logic [BW-1:0] rd_left, wr_left, grp_n;
  logic [2:0]    sub;
  logic          abt_pend, tc_q, err_q, ab_q;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m,
                                         input logic [1:0] w);
    case (m)
      2'd0:    step = a + (AW'(1) << w);
      2'd1:    step = a - (AW'(1) << w);
      default: step = a;
    endcase
  endfunction

  function automatic logic [BW-1:0] grp(input logic [CW-1:0] r, input logic [3:0] b);
    logic [31:0] bl, rr;
    bl = (b > 4'd10) ? 32'd1024 : (32'd1 << b);
    rr = 32'(r);
    grp = (rr < bl) ? rr[BW-1:0] : bl[BW-1:0];
  endfunction

  wire [2:0] sub_top = 3'((4'd1 << (sw - dw)) - 4'd1);
  wire       abt_now = abt_pend | abort_i;

  assign mem_req_o  = (st != IDLE);
  assign mem_we_o   = (st == WR);
  assign mem_addr_o = (st == WR) ? dst_a : src_a;
  assign mem_size_o = (st == WR) ? dw : sw;
  assign residue_o  = res;
  assign busy_o     = (st != IDLE);
  assign tc_o       = tc_q;
  assign err_o      = err_q;
  assign abort_o    = ab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; src_a <= '0; dst_a <= '0; sw <= '0; dw <= '0; sm <= '0; dm <= '0;
      bc <= '0; res <= '0; rd_left <= '0; wr_left <= '0; grp_n <= '0; sub <= '0;
      abt_pend <= 1'b0; tc_q <= 1'b0; err_q <= 1'b0; ab_q <= 1'b0;
    end else begin
      tc_q <= 1'b0; err_q <= 1'b0; ab_q <= 1'b0;
      abt_pend <= (st != IDLE) && abt_now;
      case (st)
        IDLE: if (start_i) begin
          src_a <= src_addr_i; dst_a <= dst_addr_i;
          sw <= src_width_i; dw <= (dst_width_i > src_width_i) ? src_width_i : dst_width_i;
          sm <= src_mode_i; dm <= dst_mode_i; bc <= burst_i; res <= size_i;
          rd_left <= grp(size_i, burst_i); grp_n <= grp(size_i, burst_i);
          if (size_i == '0) tc_q <= 1'b1;
          else st <= RD;
        end
        RD: if (mem_ack_i) begin
          if (mem_err_i) begin
            st <= IDLE; err_q <= 1'b1; abt_pend <= 1'b0;
          end else begin
            src_a <= step(src_a, sm, sw);
            if (abt_now) begin
              st <= IDLE; ab_q <= 1'b1; abt_pend <= 1'b0;
            end else if (rd_left == BW'(1)) begin
              st <= WR; wr_left <= grp_n; sub <= sub_top;
            end else rd_left <= rd_left - BW'(1);
          end
        end
        WR: if (mem_ack_i) begin
          if (mem_err_i) begin
            st <= IDLE; err_q <= 1'b1; abt_pend <= 1'b0;
          end else begin
            dst_a <= step(dst_a, dm, dw);
            if (sub == 3'd0) begin
              res <= res - CW'(1);
              if (res == CW'(1)) begin
                st <= IDLE; tc_q <= 1'b1; abt_pend <= 1'b0;
              end else if (abt_now) begin
                st <= IDLE; ab_q <= 1'b1; abt_pend <= 1'b0;
              end else if (wr_left == BW'(1)) begin
                st <= RD;
                rd_left <= grp(res - CW'(1), bc);
                grp_n   <= grp(res - CW'(1), bc);
              end else begin
                wr_left <= wr_left - BW'(1); sub <= sub_top;
              end
            end else begin
              sub <= sub - 3'd1;
              if (abt_now) begin
                st <= IDLE; ab_q <= 1'b1; abt_pend <= 1'b0;
              end
            end
          end
        end
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [1:0]    mem_size_o,
  input logic          mem_ack_i,
  input logic          mem_err_i,
  input logic [CW-1:0] residue_o,
  input logic          busy_o,
  input logic          tc_o,
  input logic          err_o,
  input logic          abort_o
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_size_o));

  assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tc_o, err_o, abort_o}));

  assert_residue_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (residue_o == $past(residue_o)) || (residue_o == $past(residue_o) - CW'(1)));

  assert_tc_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_o |-> residue_o == '0 && !busy_o && !mem_req_o);

  assert_err_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(mem_ack_i && mem_err_i) && !busy_o && residue_o == $past(residue_o));

  assert_abort_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> $past(mem_ack_i) && !busy_o);
endmodule

bind dma_seq dma_seq_chk #(.AW(AW), .CW(CW)) chk (
  .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
  .mem_addr_o(mem_addr_o), .mem_size_o(mem_size_o), .mem_ack_i(mem_ack_i),
  .mem_err_i(mem_err_i), .residue_o(residue_o), .busy_o(busy_o), .tc_o(tc_o),
  .err_o(err_o), .abort_o(abort_o));

// File: tb/tb_dma_seq.sv
module tb_dma_seq;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, abort_i = 0, mem_ack_i, mem_err_i;
  logic [31:0] src_addr_i = 0, dst_addr_i = 0, mem_addr_o;
  logic [1:0] src_width_i = 0, dst_width_i = 0, src_mode_i = 0, dst_mode_i = 0, mem_size_o;
  logic [3:0] burst_i = 0;
  logic [15:0] size_i = 0, residue_o;
  logic mem_req_o, mem_we_o, busy_o, tc_o, err_o, abort_o;

  int checks = 0, errors = 0;
  int err_at = -1;
  logic clr = 0;
  int nbeats, tc_cnt, err_cnt, ab_cnt;
  logic        l_we [0:511];
  logic [31:0] l_addr [0:511];
  logic [1:0]  l_size [0:511];
  logic        e_we [0:511];
  logic [31:0] e_addr [0:511];
  logic [1:0]  e_size [0:511];
  logic        e_ud [0:511];
  int e_n;

  always #5 clk = ~clk;

  dma_seq dut (.*);

  always @(posedge clk) begin
    if (!rst_n) begin mem_ack_i <= 0; mem_err_i <= 0; end
    else begin
      mem_ack_i <= mem_req_o && !mem_ack_i;
      mem_err_i <= mem_req_o && !mem_ack_i && (nbeats == err_at);
    end
  end

  always @(posedge clk) begin
    if (clr) begin nbeats <= 0; tc_cnt <= 0; err_cnt <= 0; ab_cnt <= 0; end
    else begin
      if (mem_req_o && mem_ack_i && nbeats < 512) begin
        l_we[nbeats] <= mem_we_o; l_addr[nbeats] <= mem_addr_o; l_size[nbeats] <= mem_size_o;
        nbeats <= nbeats + 1;
      end
      tc_cnt <= tc_cnt + int'(tc_o);
      err_cnt <= err_cnt + int'(err_o);
      ab_cnt <= ab_cnt + int'(abort_o);
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] stepf(input logic [31:0] a, input logic [1:0] m, input int w);
    if (m == 0) return a + (32'd1 << w);
    if (m == 1) return a - (32'd1 << w);
    return a;
  endfunction

  task automatic build(input logic [31:0] sa0, da0, input int sw, dw, b,
                       input logic [1:0] sm, dm, input int size);
    int blen = (b > 10) ? 1024 : (1 << b);
    int dwe = (dw > sw) ? sw : dw;
    int nsub = 1 << (sw - dwe);
    int res = size;
    logic [31:0] sa = sa0, da = da0;
    e_n = 0;
    while (res > 0) begin
      int g = (res < blen) ? res : blen;
      for (int i = 0; i < g; i++) begin
        e_we[e_n] = 0; e_addr[e_n] = sa; e_size[e_n] = 2'(sw); e_ud[e_n] = 0; e_n++;
        sa = stepf(sa, sm, sw);
      end
      for (int u = 0; u < g; u++)
        for (int s = 0; s < nsub; s++) begin
          e_we[e_n] = 1; e_addr[e_n] = da; e_size[e_n] = 2'(dwe); e_ud[e_n] = (s == nsub - 1); e_n++;
          da = stepf(da, dm, dwe);
        end
      res -= g;
    end
  endtask

  task automatic run(input string nm, input logic [31:0] sa, da, input int sw, dw, b,
                     input logic [1:0] sm, dm, input int size,
                     input int erra, input int abta, input bit mid_start);
    int last, done_units, exp_res, cyc;
    bit sent_ab = 0, sent_st = 0;
    @(negedge clk); clr = 1; err_at = erra;
    @(negedge clk); clr = 0;
    src_addr_i = sa; dst_addr_i = da; src_width_i = 2'(sw); dst_width_i = 2'(dw);
    burst_i = 4'(b); src_mode_i = sm; dst_mode_i = dm; size_i = 16'(size); start_i = 1;
    @(negedge clk); start_i = 0;
    chk(busy_o == (size != 0), {nm, " R2 busy after start"}, busy_o, size != 0);
    chk(residue_o == 16'(size), {nm, " R2 residue loaded"}, residue_o, size);
    cyc = 0;
    while (busy_o && cyc < 20000) begin
      if (abort_i) abort_i = 0;
      if (start_i) start_i = 0;
      if (abta >= 0 && !sent_ab && nbeats == abta) begin abort_i = 1; sent_ab = 1; end
      if (mid_start && !sent_st && nbeats == 1) begin
        src_addr_i = 32'hDEAD0000; size_i = 16'd77; start_i = 1; sent_st = 1;
      end
      @(negedge clk); cyc++;
    end
    abort_i = 0; start_i = 0;
    chk(cyc < 20000, {nm, " transfer finished"}, cyc, 0);
    @(negedge clk); @(negedge clk);
    build(sa, da, sw, dw, b, sm, dm, size);
    last = e_n;
    if (erra >= 0 && erra < e_n) last = erra;
    else if (abta >= 0 && abta < e_n) last = abta + 1;
    done_units = 0;
    for (int i = 0; i < ((erra >= 0 && erra < e_n) ? erra : last); i++) done_units += int'(e_ud[i]);
    exp_res = size - done_units;
    chk(nbeats == ((erra >= 0 && erra < e_n) ? erra + 1 : last), {nm, " R3 beat count"},
        nbeats, (erra >= 0 && erra < e_n) ? erra + 1 : last);
    for (int i = 0; i < last && i < nbeats; i++)
      chk(l_we[i] == e_we[i] && l_addr[i] == e_addr[i] && l_size[i] == e_size[i],
          $sformatf("%s R3 R4 R5 beat %0d we/addr/size", nm, i),
          {31'(l_we[i]), l_addr[i], l_size[i]}, {31'(e_we[i]), e_addr[i], e_size[i]});
    chk(residue_o == 16'(exp_res), {nm, " R6 R9 final residue"}, residue_o, exp_res);
    if (erra >= 0 && erra < e_n)
      chk(err_cnt == 1 && tc_cnt == 0 && ab_cnt == 0, {nm, " R9 error pulse"}, err_cnt, 1);
    else if (abta >= 0 && abta < e_n - 1)
      chk(ab_cnt == 1 && tc_cnt == 0 && err_cnt == 0, {nm, " R10 abort pulse"}, ab_cnt, 1);
    else
      chk(tc_cnt == 1 && ab_cnt == 0 && err_cnt == 0, {nm, " R7 R11 single tc pulse"}, tc_cnt, 1);
    chk(!busy_o && !mem_req_o, {nm, " R7 idle after end"}, {busy_o, mem_req_o}, 0);
    err_at = -1;
  endtask

  task automatic t_reset();
    chk(!busy_o && !mem_req_o, "R1 busy/req low at reset", {busy_o, mem_req_o}, 0);
    chk(residue_o == 0, "R1 residue zero at reset", residue_o, 0);
    chk(!tc_o && !err_o && !abort_o, "R1 pulses low at reset", {tc_o, err_o, abort_o}, 0);
  endtask

  task automatic t_idle_abort();
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; abort_i = 1;
    @(negedge clk); abort_i = 0; @(negedge clk);
    chk(!abort_o && ab_cnt == 0 && !busy_o, "R10 abort ignored while idle", ab_cnt, 0);
    run("idle_abort_then_run", 32'h40, 32'h80, 1, 1, 0, 2'd0, 2'd0, 3, -1, -1, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    run("basic_inc", 32'h100, 32'h200, 2, 2, 1, 2'd0, 2'd0, 3, -1, -1, 0);
    run("dec_src_fixed_dst", 32'h1000, 32'h3000, 1, 1, 2, 2'd1, 2'd2, 6, -1, -1, 0);
    run("narrow_dst", 32'h500, 32'h900, 2, 0, 0, 2'd0, 2'd0, 2, -1, -1, 0);
    run("wide_dst_clamped", 32'h20, 32'h60, 0, 3, 1, 2'd0, 2'd1, 3, -1, -1, 0);
    run("burst_max_code", 32'h0, 32'h8000, 3, 0, 10, 2'd0, 2'd0, 5, -1, -1, 0);
    run("burst_code_over", 32'h0, 32'h100, 0, 0, 15, 2'd3, 2'd0, 4, -1, -1, 0);
    run("size_zero", 32'h10, 32'h20, 2, 2, 0, 2'd0, 2'd0, 0, -1, -1, 0);
    run("error_mid", 32'h100, 32'h200, 2, 1, 1, 2'd0, 2'd0, 4, 5, -1, 0);
    run("error_first", 32'h100, 32'h200, 2, 2, 2, 2'd0, 2'd0, 4, 0, -1, 0);
    run("abort_mid", 32'h100, 32'h200, 1, 0, 1, 2'd0, 2'd0, 4, -1, 3, 0);
    run("abort_last_beat", 32'h100, 32'h200, 2, 2, 0, 2'd0, 2'd0, 2, -1, 3, 0);
    run("start_while_busy", 32'h700, 32'h7700, 2, 2, 1, 2'd0, 2'd0, 4, -1, -1, 1);
    t_idle_abort();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule